// File: doc/BRIEF.md
# Processor Condition-Flag Status Register

This block holds the eight-bit condition word of a small processor core. Each cycle the ALU can hand it a new zero flag, digit carry and carry, with one update enable per flag. An instruction that names this register as its destination can also write it like any other register. Two system bits record how the core last left a low-power or supervised state. The watchdog and the sleep logic drive them as events. Software cannot load them.

The flag inputs win over a destination write. When an instruction both moves data into the register and updates any of the three arithmetic flags, the data write is blocked for all three flag bits. Flags with an update enable take the ALU value. The other flags keep their old value. The two system bits accept no data writes at all. The carry and digit carry are stored exactly as the ALU supplies them. The ALU forms a subtraction by adding the two's complement, so these bits read as inverted borrows after a subtract. The block's read value is presented combinationally from the registered state.

Top module: `alu_stat_reg`

## Requirements
- R1: After the asynchronous active-low reset, the read value is 8'h18: time-out (bit 4) = 1, power-down (bit 3) = 1, zero (bit 2), digit carry (bit 1) and carry (bit 0) = 0.
- R2: Read bits 7, 6 and 5 are always 0.
- R3: A flag whose update enable (enable bit 2 = zero, 1 = digit carry, 0 = carry) is high takes its supplied value on the next clock edge.
- R4: A data write with all three update enables low loads write bits 2..0 into zero, digit carry and carry on the next edge.
- R5: If any update enable is high in the same cycle as a data write, the write has no effect on bits 2..0. Enabled flags take the ALU value and the others hold. For example, a clear with only the zero update (value 1) gives 000u u1uu.
- R6: Data writes never change the time-out and power-down bits.
- R7: A watchdog time-out event clears the time-out bit on the next edge. It takes priority over sleep and watchdog clear.
- R8: A sleep event clears power-down and sets time-out, unless a time-out event occurs in the same cycle.
- R9: A watchdog clear sets both time-out and power-down. A sleep event in the same cycle keeps power-down at 0.
- R10: With no enable, write or event, the register holds its value.
- R11: The carry and digit carry hold the ALU carry-outs without inversion. After a subtraction a - b done as a + ~b + 1, carry = 1 when a >= b (no borrow) and digit carry = 1 when a[3:0] >= b[3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_upd | input | 3 | Update enables: [2] zero, [1] digit carry, [0] carry |
| flag_val | input | 3 | ALU flag values, same bit order |
| dst_we | input | 1 | Destination data write strobe |
| dst_data | input | 8 | Destination write data |
| wdt_clear | input | 1 | Watchdog clear event |
| wdt_expire | input | 1 | Watchdog time-out event |
| sleep_enter | input | 1 | Sleep instruction executed |
| stat_rd | output | 8 | Register read value |
| zero_o | output | 1 | Zero flag |
| dcarry_o | output | 1 | Digit carry flag |
| carry_o | output | 1 | Carry flag |
| tout_o | output | 1 | Time-out bit |
| pdown_o | output | 1 | Power-down bit |

## Verification
The bench drives a data write together with a single flag update. A per-bit mask would let the write leak into the unenabled flags, and a design that let the write win would lose the ALU result. It writes ones to bits 4 and 3 while those bits are clear. A writable system bit would then read back as 1. It raises time-out, sleep and watchdog clear in the same cycle, where a wrong event priority leaves time-out or power-down set. It feeds subtraction carry-outs computed in the bench, so an inverted borrow storage shows up as a flipped carry.

// File: rtl/alu_stat_pkg.sv
package alu_stat_pkg;
  localparam int unsigned STAT_W   = 8;
  localparam int unsigned NFLAG    = 3;
  localparam int unsigned POS_C    = 0;
  localparam int unsigned POS_DC   = 1;
  localparam int unsigned POS_Z    = 2;
  localparam int unsigned POS_PD   = 3;
  localparam int unsigned POS_TO   = 4;
  localparam int unsigned USED_W   = POS_TO + 1;
  localparam int unsigned PAD_W    = STAT_W - USED_W;

  typedef struct packed {
    logic tout;
    logic pdown;
  } sys_bits_t;

  localparam sys_bits_t SYS_RST = '{tout: 1'b1, pdown: 1'b1};
endpackage

// File: rtl/stat_flag_bank.sv
module stat_flag_bank
  import alu_stat_pkg::*;
#(
  parameter int unsigned N = NFLAG
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] upd,
  input  logic [N-1:0] val,
  input  logic         we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] q
);
  logic         any_upd;
  logic [N-1:0] q_nx;

  assign any_upd = |upd;

  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      always_comb begin
        if (upd[i])
          q_nx[i] = val[i];
        else if (we && !any_upd)
          q_nx[i] = wdata[i];
        else
          q_nx[i] = q[i];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= '0;
    else
      q <= q_nx;
  end
endmodule

// File: rtl/stat_sys_bits.sv
module stat_sys_bits
  import alu_stat_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr_ev,
  input  logic      expire_ev,
  input  logic      sleep_ev,
  output sys_bits_t q
);
  sys_bits_t q_nx;

  always_comb begin
    q_nx = q;
    if (expire_ev)
      q_nx.tout = 1'b0;
    else if (clr_ev || sleep_ev)
      q_nx.tout = 1'b1;
    if (sleep_ev)
      q_nx.pdown = 1'b0;
    else if (clr_ev)
      q_nx.pdown = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= SYS_RST;
    else
      q <= q_nx;
  end
endmodule

// File: rtl/alu_stat_reg.sv
module alu_stat_reg
  import alu_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NFLAG-1:0]  flag_upd,
  input  logic [NFLAG-1:0]  flag_val,
  input  logic              dst_we,
  input  logic [STAT_W-1:0] dst_data,
  input  logic              wdt_clear,
  input  logic              wdt_expire,
  input  logic              sleep_enter,
  output logic [STAT_W-1:0] stat_rd,
  output logic              zero_o,
  output logic              dcarry_o,
  output logic              carry_o,
  output logic              tout_o,
  output logic              pdown_o
);
  logic [NFLAG-1:0] flags_q;
  sys_bits_t        sys_q;

  stat_flag_bank #(.N(NFLAG)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (flag_upd),
    .val   (flag_val),
    .we    (dst_we),
    .wdata (dst_data[NFLAG-1:0]),
    .q     (flags_q)
  );

  stat_sys_bits u_sys (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_ev    (wdt_clear),
    .expire_ev (wdt_expire),
    .sleep_ev  (sleep_enter),
    .q         (sys_q)
  );

  assign zero_o   = flags_q[POS_Z];
  assign dcarry_o = flags_q[POS_DC];
  assign carry_o  = flags_q[POS_C];
  assign tout_o   = sys_q.tout;
  assign pdown_o  = sys_q.pdown;
  assign stat_rd  = {{PAD_W{1'b0}}, sys_q.tout, sys_q.pdown, flags_q};
endmodule

// File: rtl/alu_stat_reg_chk.sv
module alu_stat_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] flag_upd,
  input logic [2:0] flag_val,
  input logic       dst_we,
  input logic       wdt_clear,
  input logic       wdt_expire,
  input logic       sleep_enter,
  input logic [7:0] stat_rd,
  input logic       zero_o,
  input logic       tout_o,
  input logic       pdown_o
);
  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd[7:5] == 3'b000);
  // R3
  zero_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_upd[2] |=> zero_o == $past(flag_val[2]));
  // R5
  write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_we && flag_upd == 3'b100) |=> $stable(stat_rd[1:0]));
  // R6
  sys_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_we && !wdt_clear && !wdt_expire && !sleep_enter) |=> ($stable(tout_o) && $stable(pdown_o)));
  // R7
  expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_expire |=> !tout_o);
  // R8
  sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_enter && !wdt_expire) |=> (tout_o && !pdown_o));
  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_clear && !sleep_enter && !wdt_expire) |=> (tout_o && pdown_o));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_upd == 3'b000 && !dst_we && !wdt_clear && !wdt_expire && !sleep_enter) |=> $stable(stat_rd));
endmodule

bind alu_stat_reg alu_stat_reg_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flag_upd    (flag_upd),
  .flag_val    (flag_val),
  .dst_we      (dst_we),
  .wdt_clear   (wdt_clear),
  .wdt_expire  (wdt_expire),
  .sleep_enter (sleep_enter),
  .stat_rd     (stat_rd),
  .zero_o      (zero_o),
  .tout_o      (tout_o),
  .pdown_o     (pdown_o)
);

// File: tb/alu_stat_reg_tb.sv
`timescale 1ns/1ps
module alu_stat_reg_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] flag_upd;
  logic [2:0] flag_val;
  logic       dst_we;
  logic [7:0] dst_data;
  logic       wdt_clear, wdt_expire, sleep_enter;
  logic [7:0] stat_rd;
  logic       zero_o, dcarry_o, carry_o, tout_o, pdown_o;

  int errors = 0;
  int checks = 0;
  logic [7:0] model;

  always #2.5 clk = ~clk;

  alu_stat_reg u_dut (
    .clk(clk), .rst_n(rst_n), .flag_upd(flag_upd), .flag_val(flag_val),
    .dst_we(dst_we), .dst_data(dst_data), .wdt_clear(wdt_clear),
    .wdt_expire(wdt_expire), .sleep_enter(sleep_enter), .stat_rd(stat_rd),
    .zero_o(zero_o), .dcarry_o(dcarry_o), .carry_o(carry_o),
    .tout_o(tout_o), .pdown_o(pdown_o)
  );

  function automatic logic [7:0] next_val(input logic [7:0] cur, input logic [2:0] up,
      input logic [2:0] v, input logic we, input logic [7:0] d,
      input logic clr, input logic exp, input logic slp);
    logic [7:0] n;
    n = cur;
    for (int i = 0; i < 3; i++) begin
      if (up[i]) n[i] = v[i];
      else if (we && up == 3'b000) n[i] = d[i];
    end
    if (exp) n[4] = 1'b0;
    else if (clr || slp) n[4] = 1'b1;
    if (slp) n[3] = 1'b0;
    else if (clr) n[3] = 1'b1;
    n[7:5] = 3'b000;
    return n;
  endfunction

  task automatic check(input string tag, input logic [7:0] exp);
    checks++;
    if (stat_rd !== exp || {tout_o, pdown_o, zero_o, dcarry_o, carry_o} !== exp[4:0]) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, stat_rd, exp);
    end
  endtask

  task automatic step(input string tag, input logic [2:0] up, input logic [2:0] v,
      input logic we, input logic [7:0] d, input logic clr, input logic exp, input logic slp);
    flag_upd = up; flag_val = v; dst_we = we; dst_data = d;
    wdt_clear = clr; wdt_expire = exp; sleep_enter = slp;
    model = next_val(model, up, v, we, d, clr, exp, slp);
    @(posedge clk);
    @(negedge clk);
    check(tag, model);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [8:0] sum;
    logic [4:0] nib;
    logic [7:0] a, b;
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    flag_upd = '0; flag_val = '0; dst_we = 1'b0; dst_data = '0;
    wdt_clear = 1'b0; wdt_expire = 1'b0; sleep_enter = 1'b0;
    #12;
    model = 8'h18;
    check("R1 reset value", 8'h18);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 after release", 8'h18);

    step("R4 plain write", 3'b000, 3'b000, 1'b1, 8'hFF, 0, 0, 0);
    step("R2 upper bits zero", 3'b000, 3'b000, 1'b1, 8'hE0, 0, 0, 0);
    step("R3 all flags update", 3'b111, 3'b101, 1'b0, 8'h00, 0, 0, 0);
    step("R10 hold", 3'b000, 3'b000, 1'b0, 8'hFF, 0, 0, 0);
    step("R5 clear with zero update", 3'b100, 3'b100, 1'b1, 8'h00, 0, 0, 0);
    step("R5 write vs carry update", 3'b001, 3'b000, 1'b1, 8'h07, 0, 0, 0);
    step("R7 expire", 3'b000, 3'b000, 1'b0, 8'h00, 0, 1, 0);
    step("R6 write ones to system bits", 3'b000, 3'b000, 1'b1, 8'h18, 0, 0, 0);
    step("R8 sleep", 3'b000, 3'b000, 1'b0, 8'h00, 0, 0, 1);
    step("R6 write ones to power-down", 3'b000, 3'b000, 1'b1, 8'hFF, 0, 0, 0);
    step("R9 clear", 3'b000, 3'b000, 1'b0, 8'h00, 1, 0, 0);
    step("R6 write zeros to system bits", 3'b000, 3'b000, 1'b1, 8'h00, 0, 0, 0);
    step("R7 expire beats sleep and clear", 3'b000, 3'b000, 1'b0, 8'h00, 1, 1, 1);
    step("R9 sleep beats clear on power-down", 3'b000, 3'b000, 1'b0, 8'h00, 1, 0, 1);

    for (int k = 0; k < 64; k++) begin
      a = 8'($urandom); b = 8'($urandom);
      if (k == 0) begin a = 8'h10; b = 8'h10; end
      if (k == 1) begin a = 8'h0F; b = 8'h10; end
      sum = {1'b0, a} + {1'b0, ~b} + 9'd1;
      nib = {1'b0, a[3:0]} + {1'b0, ~b[3:0]} + 5'd1;
      step("R11 subtract carries", 3'b111, {sum[7:0] == 8'h00, nib[4], sum[8]}, 1'b0, 8'h00, 0, 0, 0);
      checks++;
      if (carry_o !== (a >= b) || dcarry_o !== (a[3:0] >= b[3:0])) begin
        errors++;
        $display("FAIL R11: actual c=%b dc=%b expected c=%b dc=%b",
                 carry_o, dcarry_o, a >= b, a[3:0] >= b[3:0]);
      end
    end

    for (int k = 0; k < 2000; k++) begin
      logic [2:0] up, v;
      logic we, clr, ex, sl;
      string tag;
      up = 3'($urandom) & 3'($urandom);
      v = 3'($urandom);
      we = 1'($urandom);
      clr = ($urandom % 8) == 0;
      ex = ($urandom % 10) == 0;
      sl = ($urandom % 9) == 0;
      if (ex) tag = "R7 random";
      else if (sl) tag = "R8 random";
      else if (clr) tag = "R9 random";
      else if (we && up != 3'b000) tag = "R5 random";
      else if (we) tag = "R4 random";
      else if (up != 3'b000) tag = "R3 random";
      else tag = "R10 random";
      step(tag, up, v, we, 8'($urandom), clr, ex, sl);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule